// File: doc/BRIEF.md
# I2C Single-Primitive Bus Master

This block is an I2C bus master that software steers one bus primitive at a time. Each accepted write to the command register starts exactly one primitive: a START condition, a STOP condition, a repeated START, the transmission of one byte, or the reception of one byte. The block then runs that primitive to completion on its own. It drives SCL and SDA in open-drain fashion: an output-enable high pulls the line low, and an output-enable low releases it. After each primitive it leaves the bus parked, so software can chain primitives into any transaction shape, including a repeated START straight after a byte with no STOP in between.

Bus timing is set in software. A clock divider produces a tick every (divider+1) system clocks. Every bus phase has its own 8-bit cycle count, counted in ticks: START setup, START hold, STOP setup, data setup, SCL low, SCL high and repeated-start release. The data hold time has a 16-bit count. When a primitive finishes, the block sets one of two sticky status bits, one for completion with ACK and one for completion with NAK. A level interrupt reports that a status bit is set, and software clears each bit by writing 1 to it.

Top module: `i2c_prim_master`

## Requirements
- R1: The command register is at address 0, and the opcode sits in bits [2:0]: 1 START, 2 STOP, 3 repeated START, 4 send byte, 5 receive byte. A write with any other opcode is ignored. A valid command is accepted only when the block is idle. Bit [8] of the command readback is the busy flag. It is high from the cycle after acceptance until the primitive completes.
- R2: A command write while busy has no effect on the bus lines, the running primitive or the status.
- R3: The timing fields read back at fixed positions. Register 2 holds START setup at [31:24], START hold at [23:16] and STOP setup at [15:8]. Register 3 holds data setup at [31:24], SCL low at [15:8] and SCL high at [7:0]. Register 4 holds the divider at [23:16] and the repeated-start release at [7:0]. Register 5 holds the data hold time at [15:0]. A phase with count N lasts N*(divider+1) clocks, and a count of 0 acts as 1.
- R4: START, from a released bus: both lines stay released for START setup, then SDA is pulled low for START hold, then SCL is pulled low.
- R5: STOP: both lines are pulled low for data setup, then SCL is released for STOP setup, then SDA is released.
- R6: Repeated START: SDA is released with SCL low for data setup, then SCL is released for the release time, then SDA is pulled low for START hold, then SCL is pulled low.
- R7: Send byte: the byte comes from command bits [31:24] and goes out MSB first, then a ninth bit with SDA released. Each bit has three phases: SCL low with the previous SDA for the data hold time, SCL low with the new SDA for SCL low, and SCL released for SCL high. The block ends with SCL low.
- R8: Receive byte: SDA is released for eight bits. The line is sampled on the edge that releases SCL, and the byte reads back from command bits [23:16], MSB first. In the ninth bit, command bit [3] clear drives ACK (SDA low), and bit [3] set leaves SDA released.
- R9: On completion, status bit 0 (done with ACK) is set for START, STOP and repeated START. For a byte, the SDA level sampled in the ninth bit decides the result: low sets bit 0, high sets bit 1 (done with NAK). The irq output is high while any status bit is set.
- R10: Status is at address 1. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. A completion in the same cycle as the clear wins.
- R11: After reset, both lines are released, the block is idle, the status is 0 and all timing fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |
| sda_in | input | 1 | Sensed SDA line level |
| irq | output | 1 | High while any status bit is set |

## Verification
The hardest case to reach from the ports is the one where the bus level the master samples is not the level it drives. This happens in the ninth bit of a send, where a slave decides ACK or NAK, and in the data bits of a receive. The bench models a slave that counts SCL falling edges from the start of each byte command. For each bit slot it pulls SDA from a chosen mask, so it can produce an ACK, a NAK and arbitrary received bytes. A reference queue, filled when each command is issued, predicts the two output enables and the busy flag for every cycle. A command written mid-run must then leave that prediction intact.

// File: rtl/i2c_prim_master.sv
module i2c_prim_master (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        scl_oe,
  output logic        sda_oe,
  input  logic        sda_in,
  output logic        irq
);

  localparam logic [2:0] A_CMD = 3'd0, A_STAT = 3'd1, A_TA = 3'd2,
                         A_TB = 3'd3, A_TC = 3'd4, A_HOLD = 3'd5;
  localparam logic [2:0] OP_START = 3'd1, OP_STOP = 3'd2, OP_RSTART = 3'd3,
                         OP_SEND = 3'd4, OP_RECV = 3'd5;
  localparam logic [3:0] LAST_BIT = 4'd8;

  typedef enum logic [3:0] {
    PH_IDLE, PH_ST_SU, PH_ST_HD, PH_SP_LO, PH_SP_SU,
    PH_RS_LO, PH_RS_REL, PH_B_HD, PH_B_LO, PH_B_HI
  } ph_t;

  logic [7:0]  t_st_su, t_st_hd, t_sp_su, t_dsu, t_slo, t_shi, t_div, t_rs;
  logic [15:0] t_dhd;

  ph_t         ph;
  logic        busy_q;
  logic [2:0]  op_q;
  logic [8:0]  tx_sh;
  logic [8:0]  sh_q;
  logic [7:0]  rx_q;
  logic [3:0]  bit_q;
  logic [1:0]  stat_q;
  logic [7:0]  div_cnt;
  logic [15:0] ph_cnt;
  logic        scl_q, sda_q;

  logic        cmd_wr, op_ok, accept, tick, ph_end, fin;
  logic [15:0] dur, dur_eff;
  logic [1:0]  done_set, clr;

  assign cmd_wr  = reg_we && (reg_addr == A_CMD);
  assign op_ok   = (reg_wdata[2:0] >= OP_START) && (reg_wdata[2:0] <= OP_RECV);
  assign accept  = cmd_wr && op_ok && !busy_q;
  assign tick    = busy_q && (div_cnt == t_div);

  always_comb begin
    case (ph)
      PH_ST_SU:  dur = {8'h00, t_st_su};
      PH_ST_HD:  dur = {8'h00, t_st_hd};
      PH_SP_LO:  dur = {8'h00, t_dsu};
      PH_SP_SU:  dur = {8'h00, t_sp_su};
      PH_RS_LO:  dur = {8'h00, t_dsu};
      PH_RS_REL: dur = {8'h00, t_rs};
      PH_B_HD:   dur = t_dhd;
      PH_B_LO:   dur = {8'h00, t_slo};
      PH_B_HI:   dur = {8'h00, t_shi};
      default:   dur = 16'd1;
    endcase
  end

  assign dur_eff = (dur == 16'd0) ? 16'd1 : dur;
  assign ph_end  = tick && (ph_cnt == dur_eff - 16'd1);
  assign fin     = ph_end && (ph == PH_ST_HD || ph == PH_SP_SU ||
                              (ph == PH_B_HI && bit_q == LAST_BIT));
  assign done_set = !fin ? 2'b00 :
                    ((ph == PH_B_HI) && sh_q[0]) ? 2'b10 : 2'b01;
  assign clr     = (reg_we && reg_addr == A_STAT) ? reg_wdata[1:0] : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_st_su <= '0; t_st_hd <= '0; t_sp_su <= '0; t_dsu <= '0;
      t_slo <= '0; t_shi <= '0; t_div <= '0; t_rs <= '0; t_dhd <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        A_TA: begin
          t_st_su <= reg_wdata[31:24];
          t_st_hd <= reg_wdata[23:16];
          t_sp_su <= reg_wdata[15:8];
        end
        A_TB: begin
          t_dsu <= reg_wdata[31:24];
          t_slo <= reg_wdata[15:8];
          t_shi <= reg_wdata[7:0];
        end
        A_TC: begin
          t_div <= reg_wdata[23:16];
          t_rs  <= reg_wdata[7:0];
        end
        A_HOLD: t_dhd <= reg_wdata[15:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE; busy_q <= 1'b0; op_q <= '0; tx_sh <= '0; sh_q <= '0;
      rx_q <= '0; bit_q <= '0; stat_q <= '0; div_cnt <= '0; ph_cnt <= '0;
      scl_q <= 1'b0; sda_q <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~clr) | done_set;

      if (accept)      div_cnt <= '0;
      else if (busy_q) div_cnt <= tick ? 8'd0 : div_cnt + 8'd1;

      if (accept)    ph_cnt <= '0;
      else if (tick) ph_cnt <= ph_end ? 16'd0 : ph_cnt + 16'd1;

      if (accept) begin
        op_q   <= reg_wdata[2:0];
        busy_q <= 1'b1;
        bit_q  <= '0;
        tx_sh  <= (reg_wdata[2:0] == OP_SEND) ? {reg_wdata[31:24], 1'b1}
                                              : {8'hFF, reg_wdata[3]};
        case (reg_wdata[2:0])
          OP_START:  begin ph <= PH_ST_SU; scl_q <= 1'b0; sda_q <= 1'b0; end
          OP_STOP:   begin ph <= PH_SP_LO; scl_q <= 1'b1; sda_q <= 1'b1; end
          OP_RSTART: begin ph <= PH_RS_LO; scl_q <= 1'b1; sda_q <= 1'b0; end
          default:   begin ph <= PH_B_HD;  scl_q <= 1'b1; end
        endcase
      end else if (ph_end) begin
        case (ph)
          PH_ST_SU:  begin ph <= PH_ST_HD; sda_q <= 1'b1; end
          PH_ST_HD:  begin ph <= PH_IDLE; busy_q <= 1'b0; scl_q <= 1'b1; end
          PH_SP_LO:  begin ph <= PH_SP_SU; scl_q <= 1'b0; end
          PH_SP_SU:  begin ph <= PH_IDLE; busy_q <= 1'b0; sda_q <= 1'b0; end
          PH_RS_LO:  begin ph <= PH_RS_REL; scl_q <= 1'b0; end
          PH_RS_REL: begin ph <= PH_ST_HD; sda_q <= 1'b1; end
          PH_B_HD:   begin ph <= PH_B_LO; sda_q <= ~tx_sh[8]; end
          PH_B_LO: begin
            ph    <= PH_B_HI;
            scl_q <= 1'b0;
            sh_q  <= {sh_q[7:0], sda_in};
          end
          PH_B_HI: begin
            scl_q <= 1'b1;
            if (bit_q == LAST_BIT) begin
              ph     <= PH_IDLE;
              busy_q <= 1'b0;
              if (op_q == OP_RECV) rx_q <= sh_q[8:1];
            end else begin
              ph    <= PH_B_HD;
              bit_q <= bit_q + 4'd1;
              tx_sh <= {tx_sh[7:0], 1'b1};
            end
          end
          default: begin ph <= PH_IDLE; busy_q <= 1'b0; end
        endcase
      end
    end
  end

  assign scl_oe = scl_q;
  assign sda_oe = sda_q;
  assign irq    = |stat_q;

  always_comb begin
    case (reg_addr)
      A_CMD:   reg_rdata = {8'h00, rx_q, 7'h00, busy_q, 8'h00};
      A_STAT:  reg_rdata = {30'h0, stat_q};
      A_TA:    reg_rdata = {t_st_su, t_st_hd, t_sp_su, 8'h00};
      A_TB:    reg_rdata = {t_dsu, 8'h00, t_slo, t_shi};
      A_TC:    reg_rdata = {8'h00, t_div, 8'h00, t_rs};
      A_HOLD:  reg_rdata = {16'h0000, t_dhd};
      default: reg_rdata = 32'h0;
    endcase
  end

endmodule

// File: rtl/i2c_prim_master_chk.sv
module i2c_prim_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic [2:0] reg_addr,
  input logic [2:0] wd_op,
  input logic       wd0,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       busy,
  input logic [1:0] stat,
  input logic [2:0] op
);

  logic valid_wr;
  assign valid_wr = reg_we && (reg_addr == 3'd0) && (wd_op >= 3'd1) && (wd_op <= 3'd5);

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && valid_wr) |=> busy); // R1

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !valid_wr) |=> ($stable(scl_oe) && $stable(sda_oe))); // R1

  AST_NO_REISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we && reg_addr == 3'd0) |=> $stable(op)); // R2

  AST_IDLE_NO_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(!scl_oe && sda_oe)); // R5

  AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (stat != 2'b00)); // R9

  AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && reg_we && reg_addr == 3'd1 && wd0) |=> !stat[0]); // R10

endmodule

bind i2c_prim_master i2c_prim_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .wd_op(reg_wdata[2:0]), .wd0(reg_wdata[0]), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .busy(busy_q), .stat(stat_q), .op(op_q)
);

// File: tb/i2c_prim_master_tb.sv
module i2c_prim_master_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        scl_oe, sda_oe, sda_in, irq;

  always #2 clk = ~clk;

  i2c_prim_master u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .sda_in(sda_in), .irq(irq)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  string cur_tag = "R11 idle";
  logic [2:0] exp_q[$];
  logic [2:0] idle_lvl = 3'b000;
  bit wr_active = 0;

  int dv, st_su, st_hd, sp_su, dsu, slo, shi, rs, dhd;

  bit       slv_en = 0;
  int       slv_k = 0;
  logic [8:0] slv_low = '0;
  always @(posedge scl_oe) slv_k <= slv_k + 1;
  assign sda_in = ~(sda_oe | (slv_en && slv_k < 9 && slv_low[8 - slv_k]));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int eff(int n);
    return (n == 0) ? 1 : n;
  endfunction

  task automatic push(bit s, bit d, int n);
    repeat (eff(n) * (dv + 1)) exp_q.push_back({1'b1, s, d});
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && !finished) begin
      logic [2:0] e;
      e = (exp_q.size() > 0) ? exp_q.pop_front() : idle_lvl;
      check({cur_tag, " scl_oe"}, scl_oe, e[1]);
      check({cur_tag, " sda_oe"}, sda_oe, e[0]);
      if (!wr_active) check({cur_tag, " R1 busy"}, reg_rdata[8], e[2]);
    end
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    wr_active = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0; reg_addr = 0; reg_wdata = 0; wr_active = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a; #1; v = reg_rdata; reg_addr = 0;
  endtask

  task automatic issue(int op, logic [7:0] b, bit nk, string tag);
    @(negedge clk);
    cur_tag = tag;
    wr_active = 1; reg_we = 1; reg_addr = 0;
    reg_wdata = {b, 20'h0, nk, op[2:0]};
    if (op == 4 || op == 5) slv_k = 0;
    case (op)
      1: begin push(0, 0, st_su); push(0, 1, st_hd); idle_lvl = 3'b011; end
      2: begin push(1, 1, dsu); push(0, 1, sp_su); idle_lvl = 3'b000; end
      3: begin push(1, 0, dsu); push(0, 0, rs); push(0, 1, st_hd); idle_lvl = 3'b011; end
      default: begin
        bit prev;
        prev = idle_lvl[0];
        for (int k = 0; k < 9; k++) begin
          bit v;
          if (op == 4) v = (k < 8) ? ~b[7-k] : 1'b0;
          else         v = (k < 8) ? 1'b0 : ~nk;
          push(1, prev, dhd); push(1, v, slo); push(0, v, shi);
          prev = v;
        end
        idle_lvl = {2'b01, prev};
      end
    endcase
    @(negedge clk);
    reg_we = 0; reg_wdata = 0; wr_active = 0;
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic set_timing();
    wr(3'd2, {st_su[7:0], st_hd[7:0], sp_su[7:0], 8'h00});
    wr(3'd3, {dsu[7:0], 8'h00, slo[7:0], shi[7:0]});
    wr(3'd4, {8'h00, dv[7:0], 8'h00, rs[7:0]});
    wr(3'd5, {16'h0, dhd[15:0]});
  endtask

  task automatic expect_stat(logic [1:0] s, string tag);
    logic [31:0] v;
    rd(3'd1, v);
    check({tag, " R9 status"}, v, {30'h0, s});
    check({tag, " R9 irq"}, irq, |s);
    wr(3'd1, 32'h3);
    rd(3'd1, v);
    check({tag, " R10 cleared"}, v, 32'h0);
  endtask

  initial begin
    logic [31:0] v;
    dv = 1; st_su = 2; st_hd = 3; sp_su = 2; dsu = 1; slo = 2; shi = 2; rs = 3; dhd = 1;
    repeat (3) @(negedge clk);
    rd(3'd0, v); check("R11 cmd readback", v, 32'h0);
    rd(3'd1, v); check("R11 status", v, 32'h0);
    rd(3'd2, v); check("R11 timing", v, 32'h0);
    check("R11 scl_oe", scl_oe, 1'b0);
    check("R11 sda_oe", sda_oe, 1'b0);
    check("R11 irq", irq, 1'b0);
    rst_n = 1;
    @(negedge clk);

    set_timing();
    rd(3'd2, v); check("R3 reg2", v, 32'h0203_0200);
    rd(3'd3, v); check("R3 reg3", v, 32'h0100_0202);
    rd(3'd4, v); check("R3 reg4", v, 32'h0001_0003);
    rd(3'd5, v); check("R3 reg5", v, 32'h0000_0001);

    issue(1, 8'h00, 0, "R4 START"); wait_idle();
    rd(3'd1, v); check("R9 START status", v, 32'h1);
    wr(3'd1, 32'h2);
    rd(3'd1, v); check("R10 write of 1 to clear bit keeps other", v, 32'h1);
    expect_stat(2'b01, "R10 after START");

    slv_en = 1; slv_low = 9'b0_0000_0001;
    issue(4, 8'hA5, 0, "R7 SEND ack"); wait_idle();
    expect_stat(2'b01, "R7 ack");

    slv_low = 9'b0;
    issue(4, 8'h3C, 0, "R7 SEND nak"); wait_idle();
    expect_stat(2'b10, "R7 nak");

    slv_en = 0;
    issue(3, 8'h00, 0, "R6 RESTART"); wait_idle();
    expect_stat(2'b01, "R6");

    slv_en = 1; slv_low = {~8'h96, 1'b0};
    issue(5, 8'h00, 0, "R8 RECV ack"); wait_idle();
    rd(3'd0, v); check("R8 rx byte", v[23:16], 8'h96);
    expect_stat(2'b01, "R8 ack");

    slv_low = {~8'h5B, 1'b0};
    issue(5, 8'h00, 1, "R8 RECV nack"); wait_idle();
    rd(3'd0, v); check("R8 rx byte nack", v[23:16], 8'h5B);
    expect_stat(2'b10, "R8 nack");

    slv_en = 0;
    issue(2, 8'h00, 0, "R5 STOP");
    repeat (2) @(negedge clk);
    cur_tag = "R2 write while busy";
    wr(3'd0, 32'hFF00_0004);
    wait_idle();
    expect_stat(2'b01, "R2 STOP only");

    cur_tag = "R1 invalid opcode";
    wr(3'd0, 32'h0000_0006);
    repeat (4) @(negedge clk);
    rd(3'd0, v); check("R1 invalid not busy", v[8], 1'b0);
    rd(3'd1, v); check("R1 invalid no status", v, 32'h0);

    dv = 0; st_su = 0; st_hd = 1; sp_su = 1; dsu = 0; slo = 1; shi = 3; rs = 1; dhd = 0;
    set_timing();
    issue(1, 8'h00, 0, "R3 START div0"); wait_idle();
    expect_stat(2'b01, "R3 START div0");
    slv_en = 1; slv_low = 9'b0_0000_0001;
    issue(4, 8'h81, 0, "R3 SEND div0"); wait_idle();
    expect_stat(2'b01, "R3 SEND div0");
    slv_en = 0;
    issue(2, 8'h00, 0, "R5 STOP div0"); wait_idle();
    expect_stat(2'b01, "R5 STOP div0");

    repeat (4) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule